// File: doc/BRIEF.md
# Floating-Point Round and Normalize Stage

This block is the last stage of a single-precision floating-point datapath. An arithmetic unit delivers a raw result: a sign, a signed exponent and a mantissa. The mantissa has one integer bit above the binary point and may carry leading zeros. Below the 36 result bits sit the extra low-order bits that the producing operation supplies. How many of those bits are meaningful depends on the operation, so a two-bit operation code comes with every result.

The stage normalizes the mantissa so that its leading bit is one, with the exponent adjusted to match. It then rounds away the extra bits using a three-way rule in which an exact tie forces the last kept bit to one. A carry out of the rounding renormalizes the result. A zero mantissa becomes a clean all-zero word. The stage then checks the exponent range and packs a 48-bit word in sign-magnitude form, together with overflow, underflow and undefined flags. A fourth operation code marks a double-precision partial result: it is normalized but truncated, never rounded.

Both sides use a valid/ready handshake. A result is taken on a clock edge where `in_valid` and `in_ready` are both high, and it appears one cycle later on the output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and flags are held unchanged and no new input is accepted. Back-pressure therefore reaches the producer in the same cycle.

Top module: `fp_round_norm`

## Requirements
- R1: The input mantissa `in_mant` is 55 bits wide. Bit 54 has weight 1, bit 53 has weight 1/2, and bits 17:0 lie below the result field. Every nonzero result is normalized: output bit 35 is 1, and the exponent equals `in_exp + 1 - n`, where n is the number of leading zeros of the masked 55-bit mantissa. This holds both for a left shift and for a right shift when bit 54 is set.
- R2: If the bits discarded after normalization are worth less than half of the last kept bit, the 36-bit mantissa is left unchanged.
- R3: If the discarded bits are worth more than half of the last kept bit, one is added to the mantissa with full carry propagation.
- R4: If the discarded bits are worth exactly half of the last kept bit, bit 0 of the mantissa is forced to 1, and nothing is added.
- R5: `in_op` selects how many low-order bits below the 36-bit field take part. Code 0 (add/subtract) keeps 4, code 1 (multiply) keeps 18, and code 2 (reciprocal and reciprocal square root) keeps 2. Input bits below that window are ignored.
- R6: When rounding carries out of the 36-bit mantissa, the result mantissa becomes 1000...0 (bit 35 set only) and the exponent increases by one.
- R7: A mantissa that is zero after masking gives an all-zero word, whatever the sign and exponent, with no flags set.
- R8: Output word layout: bit 47 is the exponent sign (1 = negative), bit 46 is the mantissa sign, bits 45:36 are the exponent magnitude, and bits 35:0 are the mantissa.
- R9: A final exponent above 1023 sets `out_ovf`. The exponent field then saturates at 1023 with bit 47 clear, and the mantissa is kept. An exponent of exactly 1023 is not flagged.
- R10: A final exponent below -1023 sets `out_unf` and gives an all-zero word. An exponent of exactly -1023 is not flagged.
- R11: `in_undef` high gives an all-zero word with only `out_undef` set. At most one flag is ever set.
- R12: Code 3 (double-precision pass) keeps all 18 low-order bits and truncates them without rounding, including on an exact tie.
- R13: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` equals `!out_valid || out_ready`. A result accepted at one edge is presented at the next edge. While `out_valid && !out_ready`, the word and flags stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw result present |
| in_ready | output | 1 | Stage can take a result this cycle |
| in_op | input | 2 | Operation code: 0 add/sub, 1 multiply, 2 reciprocal, 3 double pass |
| in_sign | input | 1 | Mantissa sign |
| in_undef | input | 1 | Upstream result is undefined |
| in_exp | input | 12 | Signed two's-complement exponent |
| in_mant | input | 55 | Unnormalized mantissa magnitude with low-order bits |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 48 | Packed sign-magnitude result |
| out_ovf | output | 1 | Exponent overflow |
| out_unf | output | 1 | Exponent underflow |
| out_undef | output | 1 | Undefined result |

## Verification
Four properties are checked on every cycle: a nonzero output mantissa has its leading bit set, a zero mantissa comes with an all-zero word, at most one flag is raised, and an underflow always gives a zero word. Also checked every cycle: overflow saturates the exponent field, and a stalled output holds its value. The rounding rule itself (below half, above half, exact tie) needs the bench's vectors, because only a known input can say whether a given output LSB is right. The same applies to the guard width chosen by each operation code, the carry renormalization, the exponent arithmetic and the exact range boundaries.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [1:0] {
    OP_ADDSUB = 2'b00,
    OP_MUL    = 2'b01,
    OP_RECIP  = 2'b10,
    OP_DBL    = 2'b11
  } fpr_op_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic undef;
  } fpr_flags_t;

endpackage

// File: rtl/fpr_lzc.sv
module fpr_lzc #(
  parameter int W  = 55,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end

  assign all_zero = (vec == '0);
endmodule

// File: rtl/fpr_rounder.sv
module fpr_rounder #(
  parameter int MW = 36,
  parameter int DW = 19
) (
  input  logic [MW-1:0] mant_in,
  input  logic [DW-1:0] disc,
  input  logic          trunc,
  output logic [MW-1:0] mant_out,
  output logic          carry
);
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

  logic [MW:0] inc;
  assign inc = {1'b0, mant_in} + {{MW{1'b0}}, 1'b1};

  always_comb begin
    mant_out = mant_in;
    carry    = 1'b0;
    if (!trunc) begin
      if (disc > HALF) begin
        carry    = inc[MW];
        mant_out = inc[MW] ? {1'b1, {(MW-1){1'b0}}} : inc[MW-1:0];
      end else if (disc == HALF) begin
        mant_out = mant_in | {{(MW-1){1'b0}}, 1'b1};
      end
    end
  end
endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
  import fpr_pkg::*;
#(
  parameter int MW  = 36,
  parameter int EMW = 10,
  parameter int EW  = 14,
  localparam int WW = MW + EMW + 2
) (
  input  logic                 sign,
  input  logic signed [EW-1:0] exp_s,
  input  logic [MW-1:0]        mant,
  input  logic                 zero,
  input  logic                 undef_in,
  output logic [WW-1:0]        word,
  output fpr_flags_t           flags
);
  localparam int EMAX = (1 << EMW) - 1;
  localparam logic signed [EW-1:0] EMAX_S = EW'(EMAX);

  logic over, under;
  logic [EMW-1:0] mag;

  assign over  = exp_s > EMAX_S;
  assign under = exp_s < -EMAX_S;
  assign mag   = EMW'(exp_s < 0 ? -exp_s : exp_s);

  always_comb begin
    word  = '0;
    flags = '0;
    if (undef_in) begin
      flags.undef = 1'b1;
    end else if (zero) begin
      word = '0;
    end else if (under) begin
      flags.unf = 1'b1;
    end else if (over) begin
      flags.ovf = 1'b1;
      word      = {1'b0, sign, {EMW{1'b1}}, mant};
    end else begin
      word = {exp_s < 0, sign, mag, mant};
    end
  end
endmodule

// File: rtl/fp_round_norm.sv
module fp_round_norm
  import fpr_pkg::*;
#(
  parameter int MANT_W = 36,
  parameter int GMAX   = 18,
  parameter int G_ADD  = 4,
  parameter int G_MUL  = 18,
  parameter int G_REC  = 2,
  parameter int EXP_W  = 12,
  parameter int EMAG_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [1:0]                 in_op,
  input  logic                       in_sign,
  input  logic                       in_undef,
  input  logic signed [EXP_W-1:0]    in_exp,
  input  logic [MANT_W+GMAX:0]       in_mant,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [MANT_W+EMAG_W+1:0]   out_word,
  output logic                       out_ovf,
  output logic                       out_unf,
  output logic                       out_undef
);
  localparam int IN_W = MANT_W + GMAX + 1;
  localparam int DW   = IN_W - MANT_W;
  localparam int CW   = $clog2(IN_W + 1);
  localparam int IEW  = EXP_W + 2;
  localparam int WW   = MANT_W + EMAG_W + 2;

  fpr_op_e op;
  int unsigned gsel;
  logic [IN_W-1:0] keep_mask, masked, shifted;
  logic [CW-1:0]   lzc;
  logic            is_zero, carry;
  logic [MANT_W-1:0] mant_r;
  logic signed [IEW-1:0] exp_n, exp_r;
  logic [WW-1:0]   word_c;
  fpr_flags_t      flags_c;

  assign op = fpr_op_e'(in_op);

  // guard window per operation; double pass keeps the full window
  always_comb begin
    case (op)
      OP_ADDSUB: gsel = G_ADD;
      OP_MUL:    gsel = G_MUL;
      OP_RECIP:  gsel = G_REC;
      default:   gsel = GMAX;
    endcase
  end

  assign keep_mask = {IN_W{1'b1}} << (GMAX - gsel);
  assign masked    = in_mant & keep_mask;

  fpr_lzc #(.W(IN_W), .CW(CW)) u_lzc (
    .vec(masked), .cnt(lzc), .all_zero(is_zero)
  );

  assign shifted = masked << lzc;
  assign exp_n   = IEW'(in_exp) + IEW'(1) - $signed(IEW'(lzc));

  fpr_rounder #(.MW(MANT_W), .DW(DW)) u_rnd (
    .mant_in (shifted[IN_W-1 -: MANT_W]),
    .disc    (shifted[DW-1:0]),
    .trunc   (op == OP_DBL),
    .mant_out(mant_r),
    .carry   (carry)
  );

  assign exp_r = exp_n + $signed(IEW'(carry));

  fpr_pack #(.MW(MANT_W), .EMW(EMAG_W), .EW(IEW)) u_pack (
    .sign(in_sign), .exp_s(exp_r), .mant(mant_r), .zero(is_zero),
    .undef_in(in_undef), .word(word_c), .flags(flags_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
      out_undef <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= word_c;
        out_ovf   <= flags_c.ovf;
        out_unf   <= flags_c.unf;
        out_undef <= flags_c.undef;
      end
    end
  end

  AST_NORM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_word[MANT_W-1:0] != '0) |-> out_word[MANT_W-1]); // R1
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_word[MANT_W-1:0] == '0) |-> out_word == '0); // R7
  AST_OVF_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_word[WW-3 -: EMAG_W] == {EMAG_W{1'b1}} && !out_word[WW-1]); // R9
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> out_word == '0); // R10
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_ovf, out_unf, out_undef})); // R11
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_ovf)); // R13
endmodule

// File: tb/sim_fp_round_norm.sv
module sim_fp_round_norm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_op = '0;
  logic in_sign = 1'b0, in_undef = 1'b0;
  logic signed [11:0] in_exp = '0;
  logic [54:0] in_mant = '0;
  logic out_valid, out_ready = 1'b1;
  logic [47:0] out_word;
  logic out_ovf, out_unf, out_undef;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_round_norm u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sign(in_sign), .in_undef(in_undef), .in_exp(in_exp),
    .in_mant(in_mant), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_ovf(out_ovf), .out_unf(out_unf), .out_undef(out_undef)
  );

  typedef struct packed {
    logic [3:0]  tg;
    logic [1:0]  op;
    logic        sg;
    logic        ud;
    logic [11:0] ex;
    logic [54:0] mn;
    logic [47:0] w;
    logic [2:0]  fl;   // {ovf, unf, undef}
  } vec_t;

  localparam int N = 25;
  localparam vec_t VECS [N] = '{
    '{4'd2,  2'd1, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000001, 18'h00000}, {2'b00, 10'h005, 36'h800000001}, 3'b000}, // R2 exact
    '{4'd2,  2'd1, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000000, 18'h1FFFF}, {2'b00, 10'h005, 36'h800000000}, 3'b000}, // R2 below half
    '{4'd3,  2'd1, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000000, 18'h20001}, {2'b00, 10'h005, 36'h800000001}, 3'b000}, // R3
    '{4'd4,  2'd1, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000002, 18'h20000}, {2'b00, 10'h005, 36'h800000003}, 3'b000}, // R4 tie even
    '{4'd4,  2'd1, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000001, 18'h20000}, {2'b00, 10'h005, 36'h800000001}, 3'b000}, // R4 tie odd
    '{4'd5,  2'd0, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000001, 18'h23FFF}, {2'b00, 10'h005, 36'h800000001}, 3'b000}, // R5 add window
    '{4'd5,  2'd1, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000001, 18'h23FFF}, {2'b00, 10'h005, 36'h800000002}, 3'b000}, // R5 mul window
    '{4'd5,  2'd2, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000001, 18'h2FFFF}, {2'b00, 10'h005, 36'h800000001}, 3'b000}, // R5 recip window
    '{4'd3,  2'd0, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000000, 18'h28000}, {2'b00, 10'h005, 36'h800000001}, 3'b000}, // R3 add op
    '{4'd6,  2'd1, 1'b0, 1'b0, 12'h005, {1'b0, 36'hFFFFFFFFF, 18'h3FFFF}, {2'b00, 10'h006, 36'h800000000}, 3'b000}, // R6 carry
    '{4'd1,  2'd1, 1'b0, 1'b0, 12'h028, {1'b0, 36'h000000001, 18'h00000}, {2'b00, 10'h005, 36'h800000000}, 3'b000}, // R1 left
    '{4'd1,  2'd1, 1'b0, 1'b0, 12'h005, {1'b1, 36'h000000000, 18'h00000}, {2'b00, 10'h006, 36'h800000000}, 3'b000}, // R1 right
    '{4'd1,  2'd1, 1'b0, 1'b0, 12'h005, {1'b1, 36'h000000001, 18'h00000}, {2'b00, 10'h006, 36'h800000001}, 3'b000}, // R1 right, tie
    '{4'd8,  2'd1, 1'b1, 1'b0, 12'hFFB, {1'b0, 36'h800000000, 18'h00000}, {2'b11, 10'h005, 36'h800000000}, 3'b000}, // R8 signs
    '{4'd7,  2'd1, 1'b1, 1'b0, 12'hFF9, {1'b0, 36'h000000000, 18'h00000}, 48'h0, 3'b000},                            // R7 zero
    '{4'd7,  2'd0, 1'b1, 1'b0, 12'h003, {1'b0, 36'h000000000, 18'h00FFF}, 48'h0, 3'b000},                            // R7 masked zero
    '{4'd9,  2'd1, 1'b0, 1'b0, 12'h400, {1'b0, 36'h800000000, 18'h00000}, {2'b00, 10'h3FF, 36'h800000000}, 3'b100}, // R9 over
    '{4'd9,  2'd1, 1'b0, 1'b0, 12'h3FF, {1'b0, 36'h800000000, 18'h00000}, {2'b00, 10'h3FF, 36'h800000000}, 3'b000}, // R9 edge
    '{4'd10, 2'd1, 1'b0, 1'b0, 12'hC00, {1'b0, 36'h800000000, 18'h00000}, 48'h0, 3'b010},                            // R10 under
    '{4'd10, 2'd1, 1'b0, 1'b0, 12'hC01, {1'b0, 36'h800000000, 18'h00000}, {2'b10, 10'h3FF, 36'h800000000}, 3'b000}, // R10 edge
    '{4'd9,  2'd1, 1'b0, 1'b0, 12'h3FF, {1'b0, 36'hFFFFFFFFF, 18'h3FFFF}, {2'b00, 10'h3FF, 36'h800000000}, 3'b100}, // R9 via carry
    '{4'd10, 2'd1, 1'b0, 1'b0, 12'hC18, {1'b0, 36'h000000001, 18'h00000}, 48'h0, 3'b010},                            // R10 via shift
    '{4'd12, 2'd3, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000000, 18'h3FFFF}, {2'b00, 10'h005, 36'h800000000}, 3'b000}, // R12 truncate
    '{4'd12, 2'd3, 1'b0, 1'b0, 12'h005, {1'b0, 36'h800000000, 18'h20000}, {2'b00, 10'h005, 36'h800000000}, 3'b000}, // R12 tie
    '{4'd11, 2'd1, 1'b0, 1'b1, 12'h005, {1'b0, 36'h800000000, 18'h00000}, 48'h0, 3'b001}                             // R11
  };

  task automatic check(input bit ok, input int req, input logic [50:0] act, input logic [50:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_op = v.op; in_sign = v.sg; in_undef = v.ud;
    in_exp = v.ex; in_mant = v.mn;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, 13, {49'd0, out_valid, in_ready}, 51'd1);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      drive(v);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && out_word == v.w && {out_ovf, out_unf, out_undef} == v.fl,
            int'(v.tg), {out_word, out_ovf, out_unf, out_undef}, {v.w, v.fl});
    end

    // R13 back-pressure: hold output while stalled, block input
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VECS[13]);
    check(out_valid && !in_ready && out_word == VECS[0].w, 13,
          {out_word, out_valid, in_ready, 1'b0}, {VECS[0].w, 3'b100});
    repeat (3) @(negedge clk);
    check(out_valid && !in_ready && out_word == VECS[0].w, 13,
          {out_word, out_valid, in_ready, 1'b0}, {VECS[0].w, 3'b100});
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, 13, {50'd0, in_ready}, 51'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_word == VECS[13].w, 13, {out_word, 3'b000}, {VECS[13].w, 3'b000});
    @(negedge clk);
    check(out_valid == 1'b0, 13, {50'd0, out_valid}, 51'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule